// File: doc/BRIEF.md
# Reference clock loss detector

This block watches a slow external reference clock and flags when it has stopped toggling. The reference is sampled on the fast local peripheral clock, passed through a two-flop synchronizer, and compared with its previous sample. Any change restarts a run-length counter. Each peripheral clock in which the level stays the same advances the counter. The counter saturates at a programmable limit, `STALL_LIMIT`. While it sits at that limit, a sticky loss flag is set.

The system keeps running from a free-running backup clock. Software polls the flag through an 8-bit control/status register on a single-cycle register bus. The same register holds two plain read/write control bits that are brought out as pins for the port logic. The register also has five reserved bits that always read as zero.

Register layout (bit index within `reg_wdata` / `reg_rdata`):
- bit 0 is the input-enable control bit.
- bit 1 is the data-source-select control bit.
- bit 4 is the loss flag (1 = reference inactive, 0 = oscillating).
- bits 2, 3, 5, 6 and 7 are reserved.

A bus write is `reg_sel && reg_we` at a clock edge.

Top module: `refclk_loss_det`

## Requirements
- R1: A synchronous reset (`rst_n` low at a clock edge) clears the loss flag, both control bits and the run counter. Afterwards the register reads 0x00.
- R2: Let the synchronized reference hold one level. Between consecutive changes it is sampled for N peripheral clocks. The flag becomes 1 if and only if N is at least `STALL_LIMIT`+1. In particular, holding for exactly `STALL_LIMIT` clocks between changes never sets it. The run counter never exceeds `STALL_LIMIT`.
- R3: A reference toggling well within the limit leaves the flag at 0 indefinitely.
- R4: A bus write with bit 4 equal to 0 clears the flag on the next clock, provided the stall condition is not present in that cycle.
- R5: A bus write with bit 4 equal to 1 leaves the flag unchanged, whether it was 0 or 1. The flag, once set, holds until cleared or reset.
- R6: Bits 0 and 1 are read/write. After a bus write they read back the written values and drive `port_in_en` (bit 0) and `port_src_sel` (bit 1).
- R7: Reserved bits 7:5 and 3:2 always read 0. Writing 1s to them has no effect.
- R8: When the stall condition and a clearing write fall in the same cycle, the flag ends up 1.
- R9: With `reg_sel` low, `reg_rdata` is 0x00 and `reg_we` causes no change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_clk_in | input | 1 | Asynchronous reference clock being monitored |
| reg_sel | input | 1 | Register select |
| reg_we | input | 1 | Write enable, valid with `reg_sel` |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data, 0 when not selected |
| port_src_sel | output | 1 | Data-source-select control bit (bit 1) |
| port_in_en | output | 1 | Input-enable control bit (bit 0) |
| ref_lost | output | 1 | Loss flag (bit 4) |

## Verification
The loss flag is the only visible trace of the counter and edge logic. A counter that restarts late, saturates wrongly or misses an edge therefore shows up as the flag rising one or more clocks early or late. The boundary pair of hold lengths `STALL_LIMIT` and `STALL_LIMIT`+1 exposes an off-by-one within a single stall window. A fault in the sticky-clear logic appears on the clock after the offending write, as `reg_rdata` bit 4 disagreeing with the reference model. The bench compares every clock, so any divergence is reported in the cycle it first becomes visible.

// File: rtl/refmon_pkg.sv
package refmon_pkg;
  typedef struct packed {
    logic [2:0] rsv_hi;
    logic       lost;
    logic [1:0] rsv_lo;
    logic       src_sel;
    logic       in_en;
  } refmon_csr_t;

  localparam int unsigned CSR_W   = 8;
  localparam int unsigned BIT_EN  = 0;
  localparam int unsigned BIT_SRC = 1;
  localparam int unsigned BIT_LOST = 4;
endpackage

// File: rtl/refmon_sync.sv
module refmon_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], async_in};
  end

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/refmon_run_counter.sv
module refmon_run_counter #(
  parameter int unsigned LIMIT = 16,
  localparam int unsigned CW = $clog2(LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sample,
  output logic [CW-1:0] run_cnt,
  output logic          at_limit
);
  localparam logic [CW-1:0] LIMIT_C = CW'(LIMIT);

  logic prev_sample;
  logic changed;

  assign changed = sample ^ prev_sample;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_sample <= 1'b0;
      run_cnt     <= '0;
    end else begin
      prev_sample <= sample;
      if (changed)                run_cnt <= '0;
      else if (run_cnt != LIMIT_C) run_cnt <= run_cnt + 1'b1;
    end
  end

  assign at_limit = (run_cnt == LIMIT_C);
endmodule

// File: rtl/refmon_csr.sv
module refmon_csr
  import refmon_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_sel,
  input  logic             reg_we,
  input  logic [CSR_W-1:0] reg_wdata,
  input  logic             stall_set,
  output logic [CSR_W-1:0] reg_rdata,
  output logic             src_sel,
  output logic             in_en,
  output logic             lost
);
  logic        wr;
  refmon_csr_t view;

  assign wr = reg_sel & reg_we;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lost    <= 1'b0;
      src_sel <= 1'b0;
      in_en   <= 1'b0;
    end else begin
      if (stall_set)                      lost <= 1'b1;
      else if (wr && !reg_wdata[BIT_LOST]) lost <= 1'b0;
      if (wr) begin
        src_sel <= reg_wdata[BIT_SRC];
        in_en   <= reg_wdata[BIT_EN];
      end
    end
  end

  always_comb begin
    view         = '0;
    view.lost    = lost;
    view.src_sel = src_sel;
    view.in_en   = in_en;
  end

  assign reg_rdata = reg_sel ? view : '0;
endmodule

// File: rtl/refclk_loss_det.sv
module refclk_loss_det
  import refmon_pkg::*;
#(
  parameter int unsigned STALL_LIMIT = 16,
  localparam int unsigned CW = $clog2(STALL_LIMIT + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_clk_in,
  input  logic       reg_sel,
  input  logic       reg_we,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       port_src_sel,
  output logic       port_in_en,
  output logic       ref_lost
);
  logic          ref_s;
  logic [CW-1:0] run_cnt;
  logic          stall_hit;

  refmon_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(ref_clk_in), .sync_out(ref_s)
  );

  refmon_run_counter #(.LIMIT(STALL_LIMIT)) u_cnt (
    .clk(clk), .rst_n(rst_n), .sample(ref_s),
    .run_cnt(run_cnt), .at_limit(stall_hit)
  );

  refmon_csr u_csr (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .stall_set(stall_hit), .reg_rdata(reg_rdata),
    .src_sel(port_src_sel), .in_en(port_in_en), .lost(ref_lost)
  );
endmodule

// File: rtl/refclk_loss_chk.sv
module refclk_loss_chk #(
  parameter int unsigned STALL_LIMIT = 16,
  localparam int unsigned CW = $clog2(STALL_LIMIT + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_sel,
  input logic          reg_we,
  input logic [7:0]    reg_wdata,
  input logic [7:0]    reg_rdata,
  input logic          port_src_sel,
  input logic          port_in_en,
  input logic          ref_lost,
  input logic          stall_hit,
  input logic [CW-1:0] run_cnt
);
  logic wr, wr_clr;
  assign wr     = reg_sel & reg_we;
  assign wr_clr = wr & ~reg_wdata[4];

  AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |=> (!ref_lost && !port_src_sel && !port_in_en)); // R1
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) run_cnt <= CW'(STALL_LIMIT)); // R2
  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n) (wr_clr && !stall_hit) |=> !ref_lost); // R4
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (ref_lost && !wr_clr) |=> ref_lost); // R5
  AST_CTL_WRITE: assert property (@(posedge clk) disable iff (!rst_n) wr |=> (port_in_en == $past(reg_wdata[0]) && port_src_sel == $past(reg_wdata[1]))); // R6
  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (reg_rdata[7:5] == 3'b000 && reg_rdata[3:2] == 2'b00)); // R7
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n) stall_hit |=> ref_lost); // R8
  AST_NOSEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !reg_sel |-> (reg_rdata == 8'h00)); // R9
  AST_NOSEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !reg_sel |=> ($stable(port_in_en) && $stable(port_src_sel))); // R9
endmodule

bind refclk_loss_det refclk_loss_chk #(.STALL_LIMIT(STALL_LIMIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .port_src_sel(port_src_sel),
  .port_in_en(port_in_en), .ref_lost(ref_lost), .stall_hit(stall_hit),
  .run_cnt(run_cnt)
);

// File: tb/refclk_loss_det_test.sv
`timescale 1ns/1ps
module refclk_loss_det_test;
  localparam int LIM = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_clk_in = 1'b0;
  logic reg_sel = 1'b0, reg_we = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic port_src_sel, port_in_en, ref_lost;

  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  refclk_loss_det #(.STALL_LIMIT(LIM)) uut (
    .clk(clk), .rst_n(rst_n), .ref_clk_in(ref_clk_in), .reg_sel(reg_sel),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .port_src_sel(port_src_sel), .port_in_en(port_in_en), .ref_lost(ref_lost)
  );

  // Behavioural reference: delay queue for synchronizer, run length as integer
  bit q_dly[$];
  bit m_last;
  int m_run;
  bit m_flag, m_src, m_en;

  initial begin
    q_dly = '{0, 0};
    m_last = 0; m_run = 0; m_flag = 0; m_src = 0; m_en = 0;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      q_dly = '{0, 0};
      m_last = 0; m_run = 0; m_flag = 0; m_src = 0; m_en = 0;
    end else begin
      bit seen;
      bit hit;
      bit wr;
      seen = q_dly[0];
      hit  = (m_run == LIM);
      wr   = reg_sel && reg_we;
      if (hit) m_flag = 1;
      else if (wr && !reg_wdata[4]) m_flag = 0;
      if (wr) begin m_src = reg_wdata[1]; m_en = reg_wdata[0]; end
      if (seen != m_last) m_run = 0;
      else if (m_run < LIM) m_run = m_run + 1;
      m_last = seen;
      void'(q_dly.pop_front());
      q_dly.push_back(ref_clk_in);
    end
  end

  function automatic logic [7:0] model_rd();
    return reg_sel ? {3'b000, m_flag, 2'b00, m_src, m_en} : 8'h00;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
    end
  endtask

  // Every-cycle comparison, sampled mid-low-phase
  always @(negedge clk) begin
    #1.5;
    if (rst_n) begin
      chk("R2/R5 flag pin", {7'd0, ref_lost}, {7'd0, m_flag});
      chk("R6 ctl pins", {6'd0, port_src_sel, port_in_en}, {6'd0, m_src, m_en});
      chk("R7/R9 rdata", reg_rdata, model_rd());
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_wr(input logic [7:0] d);
    @(negedge clk);
    reg_sel = 1; reg_we = 1; reg_wdata = d;
    @(negedge clk);
    reg_we = 0; reg_wdata = 8'h00;
  endtask

  task automatic toggles(input int hold, input int reps);
    for (int i = 0; i < reps; i++) begin
      @(negedge clk);
      ref_clk_in = ~ref_clk_in;
      cyc(hold - 1);
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cyc(3);
    reg_sel = 1;
    rst_n = 1;
    @(negedge clk); #1;
    chk("R1 reset value", reg_rdata, 8'h00);

    toggles(4, 30);
    chk("R3 fast toggling no flag", reg_rdata, 8'h00);

    toggles(LIM, 6);
    chk("R2 hold of exactly limit", reg_rdata, 8'h00);

    toggles(LIM + 1, 2);
    cyc(4); #1;
    chk("R2 hold of limit+1 sets", reg_rdata, 8'h10);

    bus_wr(8'h10); #1;
    chk("R5 write 1 keeps flag", reg_rdata, 8'h10);

    bus_wr(8'h00); #1;
    chk("R8 set wins while stalled", reg_rdata, 8'h10);

    toggles(3, 4);
    bus_wr(8'h03); #1;
    chk("R4 write 0 clears", reg_rdata, 8'h03);

    bus_wr(8'hFF); #1;
    chk("R7 reserved ignored, R5 no set", reg_rdata, 8'h03);
    chk("R6 pins follow", {6'd0, port_src_sel, port_in_en}, 8'h03);

    bus_wr(8'h02); #1;
    chk("R6 select only", reg_rdata, 8'h02);

    @(negedge clk);
    reg_sel = 0; reg_we = 1; reg_wdata = 8'h01;
    #1;
    chk("R9 rdata zero unselected", reg_rdata, 8'h00);
    @(negedge clk);
    reg_we = 0; reg_sel = 1; #1;
    chk("R9 unselected write ignored", reg_rdata, 8'h02);

    cyc(LIM + 8); #1;
    chk("R2 long stall sets", reg_rdata, 8'h12);
    cyc(3 * LIM); #1;
    chk("R5 flag stays set", reg_rdata, 8'h12);

    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1; #1;
    chk("R1 reset clears", reg_rdata, 8'h00);
    cyc(LIM + 6); #1;
    chk("R2 set after reset with idle input", reg_rdata, 8'h10);

    cyc(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule